// File: doc/BRIEF.md
# Paged Flash Erase Sequencer

This block turns one erase request, given as a byte start address and a byte length, into a series of erase commands for a serial flash. The flash is reached through a byte-wide, handshaked SPI master port. The block first checks the request. It divides the start address and the length by the configured page size, and rejects the request if either division leaves a remainder or if the range runs past the end of the device.

A valid request is then walked page by page. At each step the block chooses between two commands. It uses a block erase, which covers 8 pages, when the current page index is a multiple of 8 and at least 8 pages remain. In every other case it erases a single page. After each command the block polls the flash status register until the ready bit is set, leaving a programmable idle gap before each poll. It gives up with a timeout if ready does not appear within a configured number of polls.

The page size, the page-to-address shift, the device size, the poll gap and the poll limit are all configuration inputs. They must stay constant while a request is in progress.

Top module: `flash_erase_seq`

## Requirements
- R1: A request whose start or length is not a whole multiple of `cfg_page_size`, or whose `cfg_page_size` is zero, produces a one-cycle `err_invalid` pulse and no SPI traffic.
- R2: A request with start + length greater than `cfg_dev_size` is rejected as in R1. Start + length equal to `cfg_dev_size` is accepted.
- R3: A step uses block erase when the current page index has its low 3 bits zero and at least 8 pages remain. Otherwise it uses page erase.
- R4: Each erase command is exactly 4 bytes sent while `spi_cs` stays high. Byte 0 is the opcode: 0x50 for block erase, 0x81 for page erase. Byte 1 is flash address bits 23:16, byte 2 is bits 15:8, and byte 3 is 0x00.
- R5: The flash address is the page index shifted left by `cfg_page_shift`, kept to 24 bits.
- R6: After each command the block sends status polls. A poll is a 2-byte transfer under its own chip-select period: 0xD7, then 0x00. The byte received during the second byte is the status, and bit 7 set means ready. Before every poll `spi_cs` is low for exactly `cfg_poll_gap`+1 cycles.
- R7: After a ready status, the page index advances by 8 pages following a block erase, or by 1 page following a page erase. The remaining page count shrinks by the same amount.
- R8: If `cfg_poll_limit` consecutive polls after one command all report busy, `err_timeout` pulses for one cycle and the block returns to idle. A limit of 0 acts as 1.
- R9: `done` pulses for one cycle when the remaining page count reaches zero. A zero-length valid request gives `done` with no SPI traffic. At most one of `done`, `err_invalid` and `err_timeout` is high in any cycle.
- R10: `req_valid` is ignored while `busy` is high. Such a request adds no commands and does not change the range being erased.
- R11: While `m_valid` is high and `m_ready` is low, `m_valid` and `m_data` hold their values into the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Start an erase request (taken only when idle) |
| req_start | input | ADDR_W | Byte start address of the range |
| req_len | input | ADDR_W | Byte length of the range |
| cfg_page_size | input | PSZ_W | Bytes per page |
| cfg_page_shift | input | SHIFT_W | Left shift from page index to flash address |
| cfg_dev_size | input | ADDR_W+1 | Device size in bytes |
| cfg_poll_gap | input | GAP_W | Extra idle cycles before each status poll |
| cfg_poll_limit | input | POLL_W | Busy polls allowed per command before timeout |
| spi_cs | output | 1 | Chip select, active high |
| m_valid | output | 1 | Byte offered to the SPI master |
| m_data | output | 8 | Byte to shift out |
| m_ready | input | 1 | SPI master accepts the offered byte |
| m_rx_valid | input | 1 | Byte received for the last accepted byte |
| m_rx_data | input | 8 | Received byte |
| busy | output | 1 | A request is in progress |
| done | output | 1 | One-cycle pulse: range fully erased |
| err_invalid | output | 1 | One-cycle pulse: request rejected |
| err_timeout | output | 1 | One-cycle pulse: ready never seen |

## Verification
The assertions assume the following about the inputs:
- The SPI master answers each accepted byte with exactly one `m_rx_valid` pulse, and never sends that pulse before the byte is accepted.
- The configuration inputs do not change while `busy` is high.
- `cfg_page_shift` is at least 8, so the low address byte is always zero.

The bench's SPI model follows these rules. It stalls `m_ready` one cycle in four and returns each received byte one cycle after acceptance. It changes the configuration only between requests, and only uses shifts of 9 and 10.

// File: rtl/erase_seq_pkg.sv
package erase_seq_pkg;

   localparam logic [7:0] OP_BLOCK_ERASE = 8'h50;
   localparam logic [7:0] OP_PAGE_ERASE  = 8'h81;
   localparam logic [7:0] OP_STATUS_RD   = 8'hD7;
   localparam logic [7:0] DUMMY_BYTE     = 8'h00;
   localparam logic [7:0] READY_MASK     = 8'h80;
   localparam int         FLASH_ADDR_W   = 24;

   typedef enum logic [2:0] {
      S_IDLE,
      S_DIV,
      S_CMD_TX,
      S_CMD_RX,
      S_POLL_WAIT,
      S_POLL_TX,
      S_POLL_RX,
      S_NEXT
   } seq_state_e;

endpackage

// File: rtl/erase_div.sv
module erase_div #(
   parameter int NUM_W = 24,
   parameter int DEN_W = 11
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             go,
   input  logic [NUM_W-1:0] num,
   input  logic [DEN_W-1:0] den,
   output logic [NUM_W-1:0] quot,
   output logic [DEN_W-1:0] rem,
   output logic             fin
);
   localparam int CNT_W = $clog2(NUM_W + 1);

   generate
      if (NUM_W < 2) begin : g_bad_num
         $error("erase_div: NUM_W must be at least 2");
      end
      if (DEN_W < 1) begin : g_bad_den
         $error("erase_div: DEN_W must be at least 1");
      end
   endgenerate

   logic [NUM_W-1:0] acc;
   logic [DEN_W-1:0] r;
   logic [CNT_W-1:0] cnt;
   logic             run;
   logic [DEN_W:0]   trial;
   logic [DEN_W:0]   diff;
   logic             take;

   assign trial = {r, acc[NUM_W-1]};
   assign take  = trial >= {1'b0, den};
   assign diff  = trial - {1'b0, den};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc <= '0;
         r   <= '0;
         cnt <= '0;
         run <= 1'b0;
         fin <= 1'b0;
      end else begin
         fin <= 1'b0;
         if (go) begin
            acc <= num;
            r   <= '0;
            cnt <= CNT_W'(NUM_W);
            run <= 1'b1;
         end else if (run) begin
            acc <= {acc[NUM_W-2:0], take};
            r   <= take ? diff[DEN_W-1:0] : trial[DEN_W-1:0];
            cnt <= cnt - 1'b1;
            if (cnt == CNT_W'(1)) begin
               run <= 1'b0;
               fin <= 1'b1;
            end
         end
      end
   end

   assign quot = acc;
   assign rem  = r;

   // R10
   div_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
      go |-> !run);

endmodule

// File: rtl/erase_step_plan.sv
module erase_step_plan #(
   parameter int PG_W     = 24,
   parameter int SHIFT_W  = 4,
   parameter int BLK_LOG2 = 3
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               chk_en,
   input  logic [PG_W-1:0]    page_idx,
   input  logic [PG_W-1:0]    pages_left,
   input  logic [SHIFT_W-1:0] shift,
   output logic               use_block,
   output logic [PG_W-1:0]    step,
   output logic               last,
   output logic [7:0]         addr_hi,
   output logic [7:0]         addr_mid
);
   import erase_seq_pkg::*;

   localparam int WIDE_W = PG_W + (1 << SHIFT_W);
   localparam logic [PG_W-1:0] BLK_PAGES = PG_W'(1 << BLK_LOG2);

   generate
      if (BLK_LOG2 < 1 || BLK_LOG2 >= PG_W) begin : g_bad_blk
         $error("erase_step_plan: BLK_LOG2 out of range");
      end
      if (WIDE_W <= FLASH_ADDR_W) begin : g_bad_wide
         $error("erase_step_plan: address path narrower than flash address");
      end
   endgenerate

   logic [WIDE_W-1:0] wide;
   logic              aligned;
   logic              enough;

   assign wide      = {{(WIDE_W-PG_W){1'b0}}, page_idx} << shift;
   assign aligned   = page_idx[BLK_LOG2-1:0] == '0;
   assign enough    = pages_left >= BLK_PAGES;
   assign use_block = aligned && enough;
   assign step      = use_block ? BLK_PAGES : PG_W'(1);
   assign last      = pages_left == step;
   assign addr_hi   = wide[23:16];
   assign addr_mid  = wide[15:8];

   // R5
   addr_fit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      chk_en |-> (wide[WIDE_W-1:FLASH_ADDR_W] == '0) && (wide[7:0] == 8'h00));

endmodule

// File: rtl/flash_erase_seq.sv
module flash_erase_seq #(
   parameter int ADDR_W   = 24,
   parameter int PSZ_W    = 11,
   parameter int SHIFT_W  = 4,
   parameter int GAP_W    = 8,
   parameter int POLL_W   = 16,
   parameter int BLK_LOG2 = 3
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                req_valid,
   input  logic [ADDR_W-1:0]   req_start,
   input  logic [ADDR_W-1:0]   req_len,
   input  logic [PSZ_W-1:0]    cfg_page_size,
   input  logic [SHIFT_W-1:0]  cfg_page_shift,
   input  logic [ADDR_W:0]     cfg_dev_size,
   input  logic [GAP_W-1:0]    cfg_poll_gap,
   input  logic [POLL_W-1:0]   cfg_poll_limit,
   output logic                spi_cs,
   output logic                m_valid,
   output logic [7:0]          m_data,
   input  logic                m_ready,
   input  logic                m_rx_valid,
   input  logic [7:0]          m_rx_data,
   output logic                busy,
   output logic                done,
   output logic                err_invalid,
   output logic                err_timeout
);
   import erase_seq_pkg::*;

   localparam int PG_W   = ADDR_W;
   localparam int N_DIV  = 2;

   generate
      if (ADDR_W < 8 || ADDR_W > 32) begin : g_bad_addr
         $error("flash_erase_seq: ADDR_W must be 8..32");
      end
      if (PSZ_W >= ADDR_W) begin : g_bad_psz
         $error("flash_erase_seq: PSZ_W must be below ADDR_W");
      end
      if (POLL_W < 1 || GAP_W < 1) begin : g_bad_cnt
         $error("flash_erase_seq: counter widths must be positive");
      end
   endgenerate

   seq_state_e         st;
   logic [ADDR_W-1:0]  lat_start;
   logic [ADDR_W-1:0]  lat_len;
   logic               div_go;
   logic [ADDR_W-1:0]  div_num [N_DIV];
   logic [ADDR_W-1:0]  div_q   [N_DIV];
   logic [PSZ_W-1:0]   div_r   [N_DIV];
   logic [N_DIV-1:0]   div_fin;
   logic [PG_W-1:0]    page_idx;
   logic [PG_W-1:0]    pages_left;
   logic [1:0]         byte_ix;
   logic [GAP_W-1:0]   gap_cnt;
   logic [POLL_W:0]    poll_cnt;
   logic               cs_q;
   logic               use_block;
   logic [PG_W-1:0]    step;
   logic               last;
   logic [7:0]         addr_hi;
   logic [7:0]         addr_mid;
   logic               range_bad;
   logic               req_bad;
   logic               flash_ready;
   logic [7:0]         cmd_byte;

   assign div_num[0] = lat_start;
   assign div_num[1] = lat_len;

   genvar gi;
   generate
      for (gi = 0; gi < N_DIV; gi++) begin : g_div
         erase_div #(.NUM_W(ADDR_W), .DEN_W(PSZ_W)) u_div (
            .clk   (clk),
            .rst_n (rst_n),
            .go    (div_go),
            .num   (div_num[gi]),
            .den   (cfg_page_size),
            .quot  (div_q[gi]),
            .rem   (div_r[gi]),
            .fin   (div_fin[gi])
         );
      end
   endgenerate

   erase_step_plan #(.PG_W(PG_W), .SHIFT_W(SHIFT_W), .BLK_LOG2(BLK_LOG2)) u_plan (
      .clk        (clk),
      .rst_n      (rst_n),
      .chk_en     (st == S_CMD_TX),
      .page_idx   (page_idx),
      .pages_left (pages_left),
      .shift      (cfg_page_shift),
      .use_block  (use_block),
      .step       (step),
      .last       (last),
      .addr_hi    (addr_hi),
      .addr_mid   (addr_mid)
   );

   assign range_bad   = ({1'b0, lat_start} + {1'b0, lat_len}) > cfg_dev_size;
   assign req_bad     = range_bad || (cfg_page_size == '0) ||
                        (div_r[0] != '0) || (div_r[1] != '0);
   assign flash_ready = (m_rx_data & READY_MASK) != 8'h00;

   always_comb begin
      case (byte_ix)
         2'd0:    cmd_byte = use_block ? OP_BLOCK_ERASE : OP_PAGE_ERASE;
         2'd1:    cmd_byte = addr_hi;
         2'd2:    cmd_byte = addr_mid;
         default: cmd_byte = 8'h00;
      endcase
   end

   always_comb begin
      m_valid = (st == S_CMD_TX) || (st == S_POLL_TX);
      if (st == S_CMD_TX)
         m_data = cmd_byte;
      else if (st == S_POLL_TX)
         m_data = (byte_ix == 2'd0) ? OP_STATUS_RD : DUMMY_BYTE;
      else
         m_data = 8'h00;
   end

   assign busy   = st != S_IDLE;
   assign spi_cs = cs_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st          <= S_IDLE;
         lat_start   <= '0;
         lat_len     <= '0;
         div_go      <= 1'b0;
         page_idx    <= '0;
         pages_left  <= '0;
         byte_ix     <= '0;
         gap_cnt     <= '0;
         poll_cnt    <= '0;
         cs_q        <= 1'b0;
         done        <= 1'b0;
         err_invalid <= 1'b0;
         err_timeout <= 1'b0;
      end else begin
         done        <= 1'b0;
         err_invalid <= 1'b0;
         err_timeout <= 1'b0;
         div_go      <= 1'b0;
         case (st)
            S_IDLE: begin
               if (req_valid) begin
                  lat_start <= req_start;
                  lat_len   <= req_len;
                  div_go    <= 1'b1;
                  st        <= S_DIV;
               end
            end
            S_DIV: begin
               if (&div_fin) begin
                  if (req_bad) begin
                     err_invalid <= 1'b1;
                     st          <= S_IDLE;
                  end else if (div_q[1] == '0) begin
                     done <= 1'b1;
                     st   <= S_IDLE;
                  end else begin
                     page_idx   <= div_q[0];
                     pages_left <= div_q[1];
                     byte_ix    <= '0;
                     cs_q       <= 1'b1;
                     st         <= S_CMD_TX;
                  end
               end
            end
            S_CMD_TX: begin
               if (m_ready) st <= S_CMD_RX;
            end
            S_CMD_RX: begin
               if (m_rx_valid) begin
                  if (byte_ix == 2'd3) begin
                     cs_q     <= 1'b0;
                     poll_cnt <= '0;
                     gap_cnt  <= cfg_poll_gap;
                     st       <= S_POLL_WAIT;
                  end else begin
                     byte_ix <= byte_ix + 2'd1;
                     st      <= S_CMD_TX;
                  end
               end
            end
            S_POLL_WAIT: begin
               if (gap_cnt == '0) begin
                  cs_q    <= 1'b1;
                  byte_ix <= '0;
                  st      <= S_POLL_TX;
               end else begin
                  gap_cnt <= gap_cnt - 1'b1;
               end
            end
            S_POLL_TX: begin
               if (m_ready) st <= S_POLL_RX;
            end
            S_POLL_RX: begin
               if (m_rx_valid) begin
                  if (byte_ix == 2'd0) begin
                     byte_ix <= 2'd1;
                     st      <= S_POLL_TX;
                  end else begin
                     cs_q <= 1'b0;
                     if (flash_ready) begin
                        page_idx   <= page_idx + step;
                        pages_left <= pages_left - step;
                        if (last) begin
                           done <= 1'b1;
                           st   <= S_IDLE;
                        end else begin
                           st <= S_NEXT;
                        end
                     end else if ((poll_cnt + 1'b1) >= {1'b0, cfg_poll_limit}) begin
                        err_timeout <= 1'b1;
                        st          <= S_IDLE;
                     end else begin
                        poll_cnt <= poll_cnt + 1'b1;
                        gap_cnt  <= cfg_poll_gap;
                        st       <= S_POLL_WAIT;
                     end
                  end
               end
            end
            S_NEXT: begin
               cs_q    <= 1'b1;
               byte_ix <= '0;
               st      <= S_CMD_TX;
            end
            default: st <= S_IDLE;
         endcase
      end
   end

   // R4
   cs_during_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
      m_valid |-> spi_cs);

   // R11
   hold_until_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
      m_valid && !m_ready |=> m_valid && $stable(m_data));

   // R9
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R9
   done_ends_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy && $past(busy));

   // R9
   outcome_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({done, err_invalid, err_timeout}));

   // R1
   invalid_no_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
      err_invalid |-> !spi_cs && !$past(spi_cs));

endmodule

// File: tb/flash_erase_seq_tb_top.sv
module flash_erase_seq_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int AW   = 24;
   localparam int PSW  = 11;
   localparam int SHW  = 4;
   localparam int GW   = 8;
   localparam int PW   = 16;
   localparam int PS   = 264;
   localparam int NPG  = 64;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            req_valid = 1'b0;
   logic [AW-1:0]   req_start = '0;
   logic [AW-1:0]   req_len = '0;
   logic [PSW-1:0]  cfg_page_size = PSW'(PS);
   logic [SHW-1:0]  cfg_page_shift = 4'd9;
   logic [AW:0]     cfg_dev_size = (AW+1)'(PS*NPG);
   logic [GW-1:0]   cfg_poll_gap = '0;
   logic [PW-1:0]   cfg_poll_limit = 16'd100;
   logic            spi_cs, m_valid, m_ready, m_rx_valid;
   logic [7:0]      m_data, m_rx_data;
   logic            busy, done, err_invalid, err_timeout;

   always #(CLK_PERIOD/2) clk = ~clk;

   flash_erase_seq dut_i (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_start(req_start),
      .req_len(req_len), .cfg_page_size(cfg_page_size), .cfg_page_shift(cfg_page_shift),
      .cfg_dev_size(cfg_dev_size), .cfg_poll_gap(cfg_poll_gap),
      .cfg_poll_limit(cfg_poll_limit), .spi_cs(spi_cs), .m_valid(m_valid),
      .m_data(m_data), .m_ready(m_ready), .m_rx_valid(m_rx_valid),
      .m_rx_data(m_rx_data), .busy(busy), .done(done),
      .err_invalid(err_invalid), .err_timeout(err_timeout)
   );

   int checks = 0;
   int errors = 0;
   logic [31:0] exp_q[$];
   int polls_seen = 0;
   int cmds_seen = 0;
   int busy_cfg = 0;
   int busy_left = 0;
   int cyc = 0;

   task automatic check_eq(input string tag, input longint act, input longint exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // SPI master model and monitor
   logic [7:0] seg [4];
   int  seg_len = 0;
   int  low_run = 0;
   int  last_low = 0;
   logic prev_cs = 1'b0;
   logic pend = 1'b0;
   logic [7:0] pend_data = 8'h00;
   int  rdy_ctr = 0;

   initial begin
      m_ready = 1'b0;
      m_rx_valid = 1'b0;
      m_rx_data = 8'h00;
   end

   always @(negedge clk) begin
      cyc++;
      if (cyc > 150000) begin
         errors++;
         $display("FAIL watchdog expired");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
      m_rx_valid = pend;
      m_rx_data  = pend_data;
      pend = 1'b0;
      if (prev_cs && !spi_cs) begin
         if (seg_len == 4) begin
            cmds_seen++;
            busy_left = busy_cfg;
            if (exp_q.size() == 0)
               check_eq("R3/R4/R5/R7 unexpected command", {seg[0], seg[1], seg[2], seg[3]}, 0);
            else
               check_eq("R3/R4/R5/R7 command", {seg[0], seg[1], seg[2], seg[3]}, exp_q.pop_front());
         end else if (seg_len == 2 && seg[0] == 8'hD7 && seg[1] == 8'h00) begin
            polls_seen++;
            check_eq("R6 cs low before poll", last_low, int'(cfg_poll_gap) + 1);
         end else begin
            check_eq("R4/R6 segment length", seg_len, 4);
         end
         seg_len = 0;
      end
      if (!prev_cs && spi_cs) begin
         last_low = low_run;
         low_run = 0;
      end
      if (!spi_cs) low_run++;
      prev_cs = spi_cs;
      rdy_ctr++;
      m_ready = rst_n && ((rdy_ctr % 4) != 3);
      if (m_valid && m_ready) begin
         if (seg_len == 1 && seg[0] == 8'hD7) begin
            if (busy_left > 0) begin
               pend_data = 8'h3C;
               busy_left--;
            end else begin
               pend_data = 8'hBC;
            end
         end else begin
            pend_data = 8'hFF;
         end
         if (seg_len < 4) seg[seg_len] = m_data;
         seg_len++;
         pend = 1'b1;
      end
   end

   // expected command list for a range in pages
   task automatic plan_cmds(input int spg, input int npg, input int sh, output int ncmd);
      int pg = spg;
      int left = npg;
      ncmd = 0;
      while (left > 0) begin
         bit blk = ((pg % 8) == 0) && (left >= 8);
         logic [31:0] a = 32'(pg) << sh;
         exp_q.push_back({blk ? 8'h50 : 8'h81, a[23:16], a[15:8], 8'h00});
         ncmd++;
         if (blk) begin
            pg += 8; left -= 8;
         end else begin
            pg += 1; left -= 1;
         end
      end
   endtask

   // kind: 0 done, 1 invalid, 2 timeout
   task automatic run_req(input int start, input int len, input int kind,
                          input int exp_polls, input bit inject, input string tag);
      int seen = 3;
      polls_seen = 0;
      @(negedge clk);
      req_start = AW'(start);
      req_len   = AW'(len);
      req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
      for (int i = 0; i < 20000; i++) begin
         if (inject && i == 40) begin
            check_eq({tag, " R10 busy at injected request"}, busy, 1);
            req_start = '0;
            req_len   = AW'(PS);
            req_valid = 1'b1;
         end
         if (inject && i == 41) req_valid = 1'b0;
         @(negedge clk);
         if (done) begin seen = 0; break; end
         if (err_invalid) begin seen = 1; break; end
         if (err_timeout) begin seen = 2; break; end
      end
      check_eq({tag, " outcome"}, seen, kind);
      repeat (3) @(negedge clk);
      check_eq({tag, " remaining expected commands"}, exp_q.size(), 0);
      check_eq({tag, " poll count"}, polls_seen, exp_polls);
      check_eq({tag, " busy after end"}, busy, 0);
      exp_q.delete();
   endtask

   initial begin
      int n;
      int c0;
      repeat (5) @(negedge clk);
      check_eq("reset busy", busy, 0);
      check_eq("reset spi_cs", spi_cs, 0);
      check_eq("reset m_valid", m_valid, 0);
      check_eq("R9 reset done", done, 0);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);

      // R3 aligned full block
      busy_cfg = 0;
      plan_cmds(0, 8, 9, n);
      run_req(0, 8*PS, 0, n*1, 1'b0, "R3 block at page 0");

      // R3/R7 unaligned start, page steps, with poll gap (R6)
      busy_cfg = 1; cfg_poll_gap = 8'd2;
      plan_cmds(3, 7, 9, n);
      run_req(3*PS, 7*PS, 0, n*2, 1'b0, "R3 R6 pages 3..9");

      // R7 block, block, page
      busy_cfg = 0; cfg_poll_gap = 8'd0;
      plan_cmds(8, 17, 9, n);
      run_req(8*PS, 17*PS, 0, n, 1'b0, "R7 pages 8..24");

      // R3 pages then block once aligned
      plan_cmds(5, 11, 9, n);
      run_req(5*PS, 11*PS, 0, n, 1'b0, "R3 pages 5..15");

      // R5 other geometry
      cfg_page_size = 11'd528; cfg_page_shift = 4'd10; cfg_dev_size = (AW+1)'(528*NPG);
      plan_cmds(1, 1, 10, n);
      run_req(528, 528, 0, n, 1'b0, "R5 shift 10");
      cfg_page_size = PSW'(PS); cfg_page_shift = 4'd9; cfg_dev_size = (AW+1)'(PS*NPG);

      // R1 misaligned start and length
      c0 = cmds_seen;
      run_req(100, PS, 1, 0, 1'b0, "R1 misaligned start");
      run_req(PS, 300, 1, 0, 1'b0, "R1 misaligned length");
      // R2 beyond device end
      run_req(60*PS, 8*PS, 1, 0, 1'b0, "R2 past end");
      check_eq("R1 R2 no commands on reject", cmds_seen - c0, 0);
      // R2 exactly at end
      plan_cmds(56, 8, 9, n);
      run_req(56*PS, 8*PS, 0, n, 1'b0, "R2 ends at device size");

      // R9 zero length
      c0 = cmds_seen;
      run_req(PS, 0, 0, 0, 1'b0, "R9 zero length");
      check_eq("R9 zero length no commands", cmds_seen - c0, 0);

      // R8 timeout
      busy_cfg = 10; cfg_poll_limit = 16'd3; cfg_poll_gap = 8'd1;
      plan_cmds(2, 1, 9, n);
      run_req(2*PS, PS, 2, 3, 1'b0, "R8 timeout");
      cfg_poll_limit = 16'd100; cfg_poll_gap = 8'd0;

      // R10 request while busy ignored
      busy_cfg = 2;
      plan_cmds(16, 16, 9, n);
      c0 = cmds_seen;
      run_req(16*PS, 16*PS, 0, n*3, 1'b1, "R10 ignore while busy");
      repeat (40) @(negedge clk);
      check_eq("R10 no extra commands", cmds_seen - c0, n);
      check_eq("R10 idle after", busy, 0);

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule